// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple synchronous request port to an external asynchronous static RAM that holds 131,072 words of 16 bits. A client raises `req` while `ready` is high and gives a write flag, a 17-bit word address, 16-bit write data and a 2-bit byte enable. The controller runs the matching read or write cycle on the memory pins and then pulses `done` for one cycle. On a read, `rdata` is valid in the same cycle as `done`.

Each phase of a memory cycle lasts a whole number of clock cycles. That number comes from a nanosecond timing parameter divided by the clock period and rounded up. A write starts with a bus-turnaround phase. During this phase the chip is selected and the data drivers are still off, so the memory can finish releasing the bus. The write-enable pulse follows, and after it comes one hold cycle in which the data is still driven. Output enable stays high for the whole write, which allows the shorter write pulse. Reads select the chip and assert output enable and the byte strobes. The data bus is captured at the end of the access count. The data bus is split into an input, an output and a per-byte driver enable, so the pad cell can sit outside the block.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low and after its release, every memory strobe (`mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n`, `mem_lb_n`) is high, `mem_dq_oe` is 0, `done` is 0 and `ready` is 1.
- R2: A read with a non-zero byte enable holds `mem_ce_n` low, `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC cycles. `be[0]` drives `mem_lb_n` low (data bits 7:0) and `be[1]` drives `mem_ub_n` low (bits 15:8). `done` and `rdata` appear RD_CYC+1 falling edges after the accepting clock edge.
- R3: In `rdata`, a byte whose enable bit is 0 reads as 8'h00, whatever the data bus carries.
- R4: Before `mem_we_n` falls, a write keeps `mem_ce_n` low with `mem_we_n`, `mem_oe_n` and all drivers off for exactly TA_CYC cycles (turnaround).
- R5: The write pulse holds `mem_we_n` low for exactly WR_CYC cycles. During the pulse `mem_ce_n` is low, `mem_oe_n` is high, the address is stable, and only the strobes of the enabled bytes are low.
- R6: The controller drives a data byte (`mem_dq_oe[0]` for bits 7:0, `mem_dq_oe[1]` for bits 15:8) only for the bytes enabled in the write. `mem_dq_out` and `mem_dq_oe` stay unchanged through the cycle in which `mem_we_n` rises.
- R7: `done` is a one-cycle pulse, and `ready` is low while a cycle is in progress. In the `done` cycle all strobes are high, the drivers are off and `ready` is 1. A write completes TA_CYC+WR_CYC+2 falling edges after the accepting edge.
- R8: A request with `be` = 2'b00 gives `done` at the first falling edge after acceptance. No memory strobe is asserted and memory contents are not changed.
- R9: The controller never drives the data bus while `mem_oe_n` is low.
- R10: Each cycle count equals ceil(t_ns / CLK_NS), with a floor of 1 for the read and write counts. RD_CYC uses the largest of the address access, read cycle and output-enable access times. WR_CYC uses the largest of the write pulse, address-to-end and data setup times. TA_CYC uses the high-impedance time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request, accepted when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled bytes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 2 | Per-byte driver enable |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
The bench keeps the 10 ns clock. It sets the address access time to 25 ns, the write pulse to 18 ns and the high-impedance time to 12 ns, which gives three read cycles, two write-pulse cycles and two turnaround cycles. With every count above one, each count register really has to step down, and an error of one in any count shows up as a wrong run length or a wrong latency. The memory model returns valid data only from the third cycle of a read, so capturing too early is caught. The model answers undriven bytes with a filler pattern, so a missing byte mask in `rdata` is caught as well.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 17,
  parameter int T_AA_NS  = 10,
  parameter int T_RC_NS  = 10,
  parameter int T_DOE_NS = 6,
  parameter int T_PWE_NS = 8,
  parameter int T_AW_NS  = 8,
  parameter int T_SD_NS  = 6,
  parameter int T_HZ_NS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        be,
  output logic              ready,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic [1:0]        mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int RD_NS   = (T_AA_NS > T_RC_NS) ? ((T_AA_NS > T_DOE_NS) ? T_AA_NS : T_DOE_NS)
                                               : ((T_RC_NS > T_DOE_NS) ? T_RC_NS : T_DOE_NS);
  localparam int WR_NS   = (T_PWE_NS > T_AW_NS) ? ((T_PWE_NS > T_SD_NS) ? T_PWE_NS : T_SD_NS)
                                                : ((T_AW_NS > T_SD_NS) ? T_AW_NS : T_SD_NS);
  localparam int RD_CYC  = (cdiv(RD_NS) < 1) ? 1 : cdiv(RD_NS);
  localparam int WR_CYC  = (cdiv(WR_NS) < 1) ? 1 : cdiv(WR_NS);
  localparam int TA_CYC  = (cdiv(T_HZ_NS) < 0) ? 0 : cdiv(T_HZ_NS);
  localparam int TA_M1   = (TA_CYC > 0) ? TA_CYC - 1 : 0;
  localparam int MAXC    = (RD_CYC > WR_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                             : ((WR_CYC > TA_CYC) ? WR_CYC : TA_CYC);
  localparam int CW      = (MAXC < 2) ? 1 : $clog2(MAXC);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_RD, S_WR, S_WEND} st_t;

  st_t              st, nst;
  logic [CW-1:0]    cnt, ncnt;
  logic [ADDR_W-1:0] a_q;
  logic [15:0]      d_q;
  logic [1:0]       be_q, bsel;
  logic             last;

  assign last       = (cnt == '0);
  assign bsel       = (st == S_IDLE) ? be : be_q;
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;

  always_comb begin
    nst  = st;
    ncnt = last ? cnt : cnt - CW'(1);
    case (st)
      S_IDLE:
        if (req && be != 2'b00) begin
          if (!wr) begin
            nst  = S_RD;
            ncnt = CW'(RD_CYC - 1);
          end else if (TA_CYC > 0) begin
            nst  = S_TURN;
            ncnt = CW'(TA_M1);
          end else begin
            nst  = S_WR;
            ncnt = CW'(WR_CYC - 1);
          end
        end
      S_TURN:
        if (last) begin
          nst  = S_WR;
          ncnt = CW'(WR_CYC - 1);
        end
      S_RD:   if (last) nst = S_IDLE;
      S_WR:   if (last) nst = S_WEND;
      S_WEND: nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      be_q      <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      ready     <= 1'b1;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 2'b00;
    end else begin
      st   <= nst;
      cnt  <= ncnt;
      done <= (st == S_RD && last) || (st == S_WEND) ||
              (st == S_IDLE && req && be == 2'b00);
      if (st == S_IDLE && req) begin
        a_q  <= addr;
        d_q  <= wdata;
        be_q <= be;
      end
      if (st == S_RD && last)
        rdata <= {be_q[1] ? mem_dq_in[15:8] : 8'h00,
                  be_q[0] ? mem_dq_in[7:0]  : 8'h00};
      ready     <= (nst == S_IDLE);
      mem_ce_n  <= (nst == S_IDLE);
      mem_oe_n  <= (nst != S_RD);
      mem_we_n  <= (nst != S_WR);
      mem_lb_n  <= !((nst == S_RD || nst == S_WR) && bsel[0]);
      mem_ub_n  <= !((nst == S_RD || nst == S_WR) && bsel[1]);
      mem_dq_oe <= (nst == S_WR || nst == S_WEND) ? bsel : 2'b00;
    end
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != 2'b00) |-> mem_oe_n);

  // R5
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && !(mem_ub_n && mem_lb_n)));

  // R5
  write_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  // R6
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe == $past(mem_dq_oe) && $stable(mem_dq_out) && !mem_ce_n));

  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TA_CYC > 0 && $fell(mem_we_n)) |-> $past(!mem_ce_n && mem_oe_n && mem_dq_oe == 2'b00));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(req && ready && be == 2'b00)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe == 2'b00));

  // R8
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready && be == 2'b00) |=> (done && mem_ce_n && mem_we_n));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int RD_C = 3;
  localparam int WR_C = 2;
  localparam int TA_C = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req, wr, ready, done;
  logic [16:0] addr, mem_addr;
  logic [15:0] wdata, rdata, mem_dq_out, mem_dq_in;
  logic [1:0]  be, mem_dq_oe;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

  sram_async_ctrl #(.CLK_NS(10), .ADDR_W(17), .T_AA_NS(25), .T_PWE_NS(18), .T_HZ_NS(12)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .ready(ready), .done(done), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] mem [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] sh_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  // Memory model and pin monitors
  logic [15:0] rd_word, last_dq;
  logic [1:0]  last_oe;
  int rd_age, rd_run, wr_run, ta_run;
  wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;

  assign mem_dq_in[7:0]  = (rd_on && !mem_lb_n && rd_age >= RD_C - 1) ? rd_word[7:0]  : 8'hEE;
  assign mem_dq_in[15:8] = (rd_on && !mem_ub_n && rd_age >= RD_C - 1) ? rd_word[15:8] : 8'hEE;

  always @(posedge clk) begin
    logic [15:0] w;
    if (!rst_n) begin
      rd_age <= 0; rd_run <= 0; wr_run <= 0; ta_run <= 0;
      rd_word <= 16'h0; last_dq <= 16'h0; last_oe <= 2'b00;
    end else begin
      if (rd_on) begin
        rd_age  <= rd_age + 1;
        rd_run  <= rd_run + 1;
        rd_word <= mem_rd(int'(mem_addr));
      end else begin
        rd_age <= 0;
        if (rd_run > 0) chk(rd_run == RD_C, "R2 R10 read strobe cycles", rd_run, RD_C);
        rd_run <= 0;
      end
      if (!mem_we_n && !mem_ce_n) begin
        if (wr_run == 0) chk(ta_run == TA_C, "R4 turnaround cycles", ta_run, TA_C);
        else chk(mem_dq_out == last_dq, "R6 data stable in pulse", int'(mem_dq_out), int'(last_dq));
        chk(mem_oe_n, "R5 oe high in write", int'(mem_oe_n), 1);
        chk(mem_dq_oe == {!mem_ub_n, !mem_lb_n}, "R6 drivers match strobes",
            int'(mem_dq_oe), int'({!mem_ub_n, !mem_lb_n}));
        w = mem_rd(int'(mem_addr));
        if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
        mem[int'(mem_addr)] = w;
        wr_run  <= wr_run + 1;
        last_dq <= mem_dq_out;
        last_oe <= mem_dq_oe;
      end else if (wr_run > 0) begin
        chk(wr_run == WR_C, "R5 R10 write pulse cycles", wr_run, WR_C);
        chk(mem_dq_oe == last_oe && mem_dq_out == last_dq, "R6 hold after pulse",
            int'(mem_dq_out), int'(last_dq));
        wr_run <= 0;
      end
      if (!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe == 2'b00) ta_run <= ta_run + 1;
      else if (mem_ce_n) ta_run <= 0;
      if (mem_dq_oe != 2'b00) chk(mem_oe_n, "R9 no bus contention", int'(mem_oe_n), 1);
    end
  end

  // Scoreboard
  typedef struct {bit rd; logic [15:0] d;} item_t;
  item_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.rd) chk(rdata == it.d, "R2 R3 read data", int'(rdata), int'(it.d));
      end
    end
  end

  task automatic do_op(input bit w, input int a, input logic [15:0] d, input logic [1:0] b);
    item_t it;
    logic [15:0] s, e;
    int lat, exp_lat;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = 17'(a); wdata = d; be = b;
    s = sh_rd(a);
    if (w) begin
      if (b[0]) s[7:0]  = d[7:0];
      if (b[1]) s[15:8] = d[15:8];
      shadow[a] = s;
    end
    e = {b[1] ? s[15:8] : 8'h00, b[0] ? s[7:0] : 8'h00};
    it.rd = !w && b != 2'b00;
    it.d  = e;
    exp_q.push_back(it);
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    if (b == 2'b00)
      chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n, "R8 no strobes",
          int'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}), 5'h1f);
    else
      chk(!ready, "R7 ready low while busy", int'(ready), 0);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = (b == 2'b00) ? 1 : (w ? TA_C + WR_C + 2 : RD_C + 1);
    chk(lat == exp_lat, (b == 2'b00) ? "R8 latency" : "R7 R10 latency", lat, exp_lat);
    chk(ready && mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && mem_dq_oe == 2'b00,
        "R7 idle at done", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 5'h1c);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; be = 2'b00;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && mem_dq_oe == 2'b00 && !done && ready,
        "R1 reset state", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 5'h1f);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe == 2'b00 && !done && ready,
        "R1 after release", int'({done, ready}), 1);

    do_op(1, 'h10, 16'h1234, 2'b11);
    do_op(0, 'h10, 16'h0000, 2'b11);
    do_op(1, 'h10, 16'hFFAB, 2'b01);
    do_op(0, 'h10, 16'h0000, 2'b11);
    do_op(1, 'h10, 16'hCDFF, 2'b10);
    do_op(0, 'h10, 16'h0000, 2'b01);   // R3 upper reads zero
    do_op(0, 'h10, 16'h0000, 2'b10);   // R3 lower reads zero
    do_op(1, 'h10, 16'h9999, 2'b00);   // R8 no write
    do_op(0, 'h10, 16'h0000, 2'b00);   // R8 empty read
    do_op(0, 'h10, 16'h0000, 2'b11);   // R8 contents unchanged
    do_op(1, 'h1FFFF, 16'hBEEF, 2'b11);
    do_op(1, 'h0, 16'h0F0F, 2'b11);
    do_op(0, 'h1FFFF, 16'h0000, 2'b11);
    do_op(0, 'h0, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++) begin
      do_op(1, 'h300 + i * 37, 16'(16'hA000 + i * 16'h0111), 2'(i % 3 + 1));
    end
    for (int i = 0; i < 8; i++) begin
      do_op(0, 'h300 + i * 37, 16'h0000, 2'b11);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all requests completed", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule